// File: doc/BRIEF.md
# PCM voice bit clock and frame sync generator

This block runs on a fixed 4 MHz system clock and produces the master-side timing for a serial voice codec link: a bit clock at 128, 256 or 512 kHz and a frame sync at 8 kHz. The bit clock is the top bit of a 24-bit phase accumulator. Each system clock adds a constant to the accumulator, so a rate that does not divide 4 MHz evenly, such as 15.625 system clocks per bit, averages out exactly over time. A bit counter advanced by the bit clock marks the frames. The sync is either a long pulse that rises at frame start or a single-bit pulse whose falling edge marks frame start.

A downstream serializer uses the registered one-cycle strobes for bit-clock rise, bit-clock fall and frame start, so it never has to detect edges itself. The configuration inputs are rate, sync style, long-pulse length, sync suppress and enable. They are sampled only at a frame boundary, so a change never produces a runt pulse or a frame of mixed length. Suppress holds the sync low while the bit clock keeps running, which lets a codec power down.

Top module: `pcm_clkgen`

## Requirements
- R1: While rst_ni is low, and afterwards until cfg_en_i is first seen high, pcm_clk_o, pcm_sync_o, bclk_rise_o, bclk_fall_o and frame_start_o are all 0.
- R2: While running, pcm_clk_o is bit 23 of a 24-bit accumulator that starts at 0 and grows by round(f·2^24/4 MHz) on each system clock. cfg_rate_i selects f: 00 gives 256 kHz, 01 gives 128 kHz, 10 gives 512 kHz and 11 also gives 256 kHz. The bit period averaged over several frames is within 1% of 4 MHz/f.
- R3: bclk_rise_o is 1 in exactly those cycles in which pcm_clk_o has just changed from 0 to 1. bclk_fall_o is 1 in exactly those cycles in which pcm_clk_o has just changed from 1 to 0.
- R4: A frame is f/8 kHz bit clocks long (16, 32 or 64). frame_start_o is 1 in the same cycle as the bclk_rise_o that begins bit 0 of each frame.
- R5: In long mode (cfg_short_i=0), pcm_sync_o rises together with frame_start_o. It stays high for 8 bit clocks when cfg_long_len_i=0 and for 16 when cfg_long_len_i=1. pcm_sync_o changes only on bit-clock rising edges, except when the block stops.
- R6: In short mode (cfg_short_i=1), pcm_sync_o is high for exactly one bit clock, the last bit of a frame, and falls together with frame_start_o. After a start from idle, no sync pulse comes before the first frame start.
- R7: With cfg_suppress_i=1 in force, pcm_sync_o stays 0 while pcm_clk_o and frame_start_o continue as in R2 and R4.
- R8: Rate, sync style, long length and suppress are taken from the inputs only at a frame start, and at a start from idle. A change in the middle of a frame leaves the rest of that frame unchanged.
- R9: From idle, with cfg_en_i high, the block starts with pcm_clk_o low, and the first rising bit-clock edge is a frame start. This takes 9 cycles at 256 kHz and 17 cycles at 128 kHz, counted from the cycle in which enable is applied. When cfg_en_i is low at a frame boundary, the block stops there instead of starting a new frame: all outputs go to 0 and stay there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 4 MHz system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Run enable |
| cfg_rate_i | input | 2 | Bit-clock rate select |
| cfg_short_i | input | 1 | 1 selects short (one-bit) sync, 0 selects long sync |
| cfg_long_len_i | input | 1 | Long sync length: 0 gives 8 bits, 1 gives 16 bits |
| cfg_suppress_i | input | 1 | Hold sync low while the clock keeps running |
| pcm_clk_o | output | 1 | Bit clock |
| pcm_sync_o | output | 1 | Frame sync |
| bclk_rise_o | output | 1 | One-cycle strobe on each bit-clock rising edge |
| bclk_fall_o | output | 1 | One-cycle strobe on each bit-clock falling edge |
| frame_start_o | output | 1 | One-cycle strobe at the start of each frame |

## Verification
The hardest case to reach is a configuration change that lands inside a frame and must not affect that frame. This matters most when rate and sync length change together, because both the frame length and the accumulator step then switch at the same boundary. The stimulus changes the inputs one cycle after a frame start and counts the bit clocks up to the next frame start, expecting the old frame length. It also stops the block in the middle of a frame and restarts it from idle in short mode, covering the stop at the boundary and the first frame, which has no preceding sync pulse. A behavioural model, stepped on every clock, tracks all outputs through these transitions.

// File: rtl/pcm_clkgen_pkg.sv
package pcm_clkgen_pkg;

  typedef enum logic [1:0] {
    RATE_MID  = 2'b00,
    RATE_LO   = 2'b01,
    RATE_HI   = 2'b10,
    RATE_RSVD = 2'b11
  } pcm_rate_e;

  typedef struct packed {
    pcm_rate_e rate;
    logic      short_fs;
    logic      long_len;
    logic      suppress;
  } pcm_cfg_t;

  localparam pcm_cfg_t CFG_DEFAULT = '{rate: RATE_MID, short_fs: 1'b0,
                                       long_len: 1'b0, suppress: 1'b0};

endpackage

// File: rtl/pcm_phase_acc.sv
module pcm_phase_acc #(
  parameter int unsigned ACC_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic             rise_now_o,
  output logic             pcm_clk_o,
  output logic             bclk_rise_o,
  output logic             bclk_fall_o
);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic             fall_now;
  logic             rise_q, fall_q;

  assign acc_d      = acc_q + inc_i;
  assign rise_now_o = ~acc_q[ACC_W-1] & acc_d[ACC_W-1];
  assign fall_now   = acc_q[ACC_W-1] & ~acc_d[ACC_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else if (clr_i) begin
      acc_q  <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      rise_q <= rise_now_o;
      fall_q <= fall_now;
    end
  end

  assign pcm_clk_o   = acc_q[ACC_W-1];
  assign bclk_rise_o = rise_q;
  assign bclk_fall_o = fall_q;

endmodule

// File: rtl/pcm_frame_ctr.sv
module pcm_frame_ctr #(
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned SYNC_BITS = 8,
  parameter int unsigned SYNC_LONG = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           rise_now_i,
  input  logic [CNT_W:0] frame_bits_i,
  input  logic           short_i,
  input  logic           long_len_i,
  input  logic           suppress_i,
  output logic           wrap_now_o,
  output logic           pcm_sync_o,
  output logic           frame_start_o
);

  localparam logic [CNT_W:0] SB = (CNT_W+1)'(SYNC_BITS);
  localparam logic [CNT_W:0] SL = (CNT_W+1)'(SYNC_LONG);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             last_bit, sync_d, sync_q, fs_q;
  logic [CNT_W:0]   last_idx;

  assign last_idx   = frame_bits_i - 1'b1;
  assign last_bit   = {1'b0, cnt_q} >= last_idx;
  assign wrap_now_o = rise_now_i & last_bit;
  assign cnt_nxt    = last_bit ? '0 : cnt_q + 1'b1;

  always_comb begin
    if (suppress_i)   sync_d = 1'b0;
    else if (short_i) sync_d = ({1'b0, cnt_nxt} == last_idx);
    else              sync_d = ({1'b0, cnt_nxt} < (long_len_i ? SL : SB));
  end

  // idle count is all ones so the first bit-clock rise wraps to bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      sync_q <= 1'b0;
      fs_q   <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '1;
      sync_q <= 1'b0;
      fs_q   <= 1'b0;
    end else if (rise_now_i) begin
      cnt_q  <= cnt_nxt;
      sync_q <= sync_d;
      fs_q   <= (cnt_nxt == '0);
    end else begin
      fs_q   <= 1'b0;
    end
  end

  assign pcm_sync_o    = sync_q;
  assign frame_start_o = fs_q;

endmodule

// File: rtl/pcm_clkgen.sv
module pcm_clkgen
  import pcm_clkgen_pkg::*;
#(
  parameter int unsigned ACC_W       = 24,
  parameter int unsigned SYS_HZ      = 4_000_000,
  parameter int unsigned FRAME_HZ    = 8_000,
  parameter int unsigned RATE_LO_HZ  = 128_000,
  parameter int unsigned RATE_MID_HZ = 256_000,
  parameter int unsigned RATE_HI_HZ  = 512_000,
  parameter int unsigned SYNC_BITS   = 8,
  parameter int unsigned SYNC_LONG   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_en_i,
  input  logic [1:0] cfg_rate_i,
  input  logic       cfg_short_i,
  input  logic       cfg_long_len_i,
  input  logic       cfg_suppress_i,
  output logic       pcm_clk_o,
  output logic       pcm_sync_o,
  output logic       bclk_rise_o,
  output logic       bclk_fall_o,
  output logic       frame_start_o
);

  localparam longint unsigned ONE_TURN = longint'(1) << ACC_W;
  localparam logic [ACC_W-1:0] INC_LO  =
    ACC_W'((longint'(RATE_LO_HZ)  * ONE_TURN + SYS_HZ / 2) / SYS_HZ);
  localparam logic [ACC_W-1:0] INC_MID =
    ACC_W'((longint'(RATE_MID_HZ) * ONE_TURN + SYS_HZ / 2) / SYS_HZ);
  localparam logic [ACC_W-1:0] INC_HI  =
    ACC_W'((longint'(RATE_HI_HZ)  * ONE_TURN + SYS_HZ / 2) / SYS_HZ);
  localparam int unsigned     BITS_MAX = RATE_HI_HZ / FRAME_HZ;
  localparam int unsigned     CNT_W    = $clog2(BITS_MAX);
  localparam logic [CNT_W:0]  NB_LO    = (CNT_W+1)'(RATE_LO_HZ / FRAME_HZ);
  localparam logic [CNT_W:0]  NB_MID   = (CNT_W+1)'(RATE_MID_HZ / FRAME_HZ);
  localparam logic [CNT_W:0]  NB_HI    = (CNT_W+1)'(BITS_MAX);

  pcm_cfg_t         cfg_in, act_q, cfg_frame;
  logic             run_q, clr, stop_now, wrap_now, rise_now;
  logic [ACC_W-1:0] inc;
  logic [CNT_W:0]   frame_bits;
  logic             act_sup;

  assign cfg_in = '{rate: pcm_rate_e'(cfg_rate_i), short_fs: cfg_short_i,
                    long_len: cfg_long_len_i, suppress: cfg_suppress_i};

  assign stop_now = run_q & wrap_now & ~cfg_en_i;
  assign clr      = ~run_q | stop_now;
  // the frame being entered takes its sync settings from the inputs
  assign cfg_frame = wrap_now ? cfg_in : act_q;
  assign act_sup   = act_q.suppress;

  always_comb begin
    unique case (act_q.rate)
      RATE_LO: begin inc = INC_LO;  frame_bits = NB_LO;  end
      RATE_HI: begin inc = INC_HI;  frame_bits = NB_HI;  end
      default: begin inc = INC_MID; frame_bits = NB_MID; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      act_q <= CFG_DEFAULT;
    end else if (!run_q) begin
      if (cfg_en_i) begin
        run_q <= 1'b1;
        act_q <= cfg_in;
      end
    end else if (wrap_now) begin
      if (cfg_en_i) act_q <= cfg_in;
      else          run_q <= 1'b0;
    end
  end

  pcm_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .inc_i       (inc),
    .rise_now_o  (rise_now),
    .pcm_clk_o   (pcm_clk_o),
    .bclk_rise_o (bclk_rise_o),
    .bclk_fall_o (bclk_fall_o)
  );

  pcm_frame_ctr #(
    .CNT_W     (CNT_W),
    .SYNC_BITS (SYNC_BITS),
    .SYNC_LONG (SYNC_LONG)
  ) u_frm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         (clr),
    .rise_now_i    (rise_now),
    .frame_bits_i  (frame_bits),
    .short_i       (cfg_frame.short_fs),
    .long_len_i    (cfg_frame.long_len),
    .suppress_i    (cfg_frame.suppress),
    .wrap_now_o    (wrap_now),
    .pcm_sync_o    (pcm_sync_o),
    .frame_start_o (frame_start_o)
  );

endmodule

// File: rtl/pcm_clkgen_chk.sv
module pcm_clkgen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pcm_clk_i,
  input logic pcm_sync_i,
  input logic rise_i,
  input logic fall_i,
  input logic fs_i,
  input logic sup_i
);

  AST_RISE_IS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |-> (pcm_clk_i && !$past(pcm_clk_i))) else $error("rise strobe off edge"); // R3
  AST_EDGE_HAS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pcm_clk_i) |-> rise_i) else $error("edge without rise strobe"); // R3
  AST_FALL_IS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_i |-> (!pcm_clk_i && $past(pcm_clk_i))) else $error("fall strobe off edge"); // R3
  AST_FS_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_i |-> rise_i) else $error("frame start off rising edge"); // R4
  AST_SYNC_UP_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pcm_sync_i) |-> rise_i) else $error("sync rose off rising edge"); // R5
  AST_SUPPRESS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_i |-> !pcm_sync_i) else $error("sync high while suppressed"); // R7

endmodule

bind pcm_clkgen pcm_clkgen_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pcm_clk_i  (pcm_clk_o),
  .pcm_sync_i (pcm_sync_o),
  .rise_i     (bclk_rise_o),
  .fall_i     (bclk_fall_o),
  .fs_i       (frame_start_o),
  .sup_i      (act_sup)
);

// File: tb/pcm_clkgen_tb_top.sv
`timescale 1ns/1ps
module pcm_clkgen_tb_top;

  localparam int CLK_PERIOD = 250;

  logic       clk_i = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] rate = 2'b00;
  logic       short_m = 1'b0, long_len = 1'b0, sup = 1'b0;
  logic       pcm_clk, pcm_sync, b_rise, b_fall, fs;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pcm_clkgen dut_i (
    .clk_i(clk_i), .rst_ni(rst_n), .cfg_en_i(en), .cfg_rate_i(rate),
    .cfg_short_i(short_m), .cfg_long_len_i(long_len), .cfg_suppress_i(sup),
    .pcm_clk_o(pcm_clk), .pcm_sync_o(pcm_sync), .bclk_rise_o(b_rise),
    .bclk_fall_o(b_fall), .frame_start_o(fs)
  );

  function automatic longint rate_hz(input logic [1:0] r);
    case (r)
      2'b01:   return 128000;
      2'b10:   return 512000;
      default: return 256000;
    endcase
  endfunction

  function automatic longint m_inc(input logic [1:0] r);
    return (rate_hz(r) * 64'd16777216 + 64'd2000000) / 64'd4000000;
  endfunction

  function automatic int m_bits(input logic [1:0] r);
    return int'(rate_hz(r) / 8000);
  endfunction

  // behavioural reference model
  bit         m_run, e_clk, e_sync, e_rise, e_fall, e_fs;
  longint     m_phase;
  int         m_cnt;
  logic [1:0] m_rate;
  bit         m_short, m_long, m_sup;

  always @(posedge clk_i or negedge rst_n) begin
    longint np;
    bit r, f, last;
    if (!rst_n) begin
      m_run = 0; m_phase = 0; m_cnt = 63; m_rate = 0;
      m_short = 0; m_long = 0; m_sup = 0;
      e_clk = 0; e_sync = 0; e_rise = 0; e_fall = 0; e_fs = 0;
    end else if (!m_run) begin
      if (en) begin
        m_run = 1; m_rate = rate; m_short = short_m; m_long = long_len; m_sup = sup;
      end
      m_phase = 0; m_cnt = 63;
      e_clk = 0; e_sync = 0; e_rise = 0; e_fall = 0; e_fs = 0;
    end else begin
      np = (m_phase + m_inc(m_rate)) % 64'd16777216;
      r = !m_phase[23] && np[23];
      f = m_phase[23] && !np[23];
      last = m_cnt >= m_bits(m_rate) - 1;
      if (r && last && !en) begin
        m_run = 0; m_phase = 0; m_cnt = 63;
        e_clk = 0; e_sync = 0; e_rise = 0; e_fall = 0; e_fs = 0;
      end else begin
        m_phase = np; e_clk = np[23]; e_rise = r; e_fall = f; e_fs = 0;
        if (r) begin
          m_cnt = last ? 0 : m_cnt + 1;
          if (m_cnt == 0) begin
            m_rate = rate; m_short = short_m; m_long = long_len; m_sup = sup;
          end
          e_fs = (m_cnt == 0);
          if (m_sup)        e_sync = 0;
          else if (m_short) e_sync = (m_cnt == m_bits(m_rate) - 1);
          else              e_sync = (m_cnt < (m_long ? 16 : 8));
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_n && !done) begin
      chk(pcm_clk == e_clk,   "R2 pcm_clk_o",     pcm_clk,  e_clk);
      chk(b_rise == e_rise,   "R3 bclk_rise_o",   b_rise,   e_rise);
      chk(b_fall == e_fall,   "R3 bclk_fall_o",   b_fall,   e_fall);
      chk(fs == e_fs,         "R4 frame_start_o", fs,       e_fs);
      chk(pcm_sync == e_sync, "R5 pcm_sync_o",    pcm_sync, e_sync);
    end
  end

  task automatic wait_fs();
    do @(negedge clk_i); while (!fs);
  endtask

  // aligned at a frame start, measure nf frames
  task automatic run_frames(input int nf, input int nbits, input int exp_w,
                            input bit shrt, input real per, input string tag);
    bit prev = 0;
    int cyc = 0, rises = 0, w, frames = 0, pol_ok;
    do begin prev = pcm_sync; @(negedge clk_i); end while (!fs);
    if (exp_w == 0)  pol_ok = (pcm_sync == 0);
    else if (shrt)   pol_ok = (pcm_sync == 0 && prev == 1);
    else             pol_ok = (pcm_sync == 1 && prev == 0);
    chk(pol_ok != 0, {tag, " frame-start sync polarity"}, pcm_sync, shrt ? 0 : (exp_w > 0));
    w = pcm_sync ? 1 : 0;
    while (frames < nf) begin
      prev = pcm_sync;
      @(negedge clk_i);
      cyc++;
      if (b_rise) begin
        rises++;
        if (fs) begin
          frames++;
          chk(w == exp_w, {tag, " sync width in bits"}, w, exp_w);
          w = 0;
        end
        if (pcm_sync) w++;
      end
    end
    chk(rises == nf * nbits, "R4 bits per frame", rises / nf, nbits);
    chk(real'(cyc) / real'(rises) > per * 0.99 && real'(cyc) / real'(rises) < per * 1.01,
        "R2 mean bit period x1000", longint'(1000.0 * real'(cyc) / real'(rises)),
        longint'(1000.0 * per));
  endtask

  initial begin
    int n, s;
    repeat (4) @(negedge clk_i);
    chk(pcm_clk == 0 && pcm_sync == 0 && b_rise == 0 && b_fall == 0 && fs == 0,
        "R1 outputs in reset", {pcm_clk, pcm_sync, b_rise, b_fall, fs}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk_i);
    chk(pcm_clk == 0 && fs == 0, "R1 idle before enable", {pcm_clk, fs}, 0);

    // default start, 256 kHz long 8
    en = 1'b1;
    n = 0;
    do begin @(negedge clk_i); n++; end while (!fs);
    chk(n == 9, "R9 start latency 256k", n, 9);
    run_frames(4, 32, 8, 0, 15.625, "R5 long8");

    long_len = 1'b1;
    wait_fs();
    run_frames(3, 32, 16, 0, 15.625, "R5 long16");

    // mid-frame change of rate and length
    @(negedge clk_i);
    rate = 2'b01; long_len = 1'b0;
    n = 0;
    do begin @(negedge clk_i); if (b_rise) n++; end while (!fs);
    chk(n == 32, "R8 old frame kept after mid-frame change", n, 32);
    run_frames(3, 16, 8, 0, 31.25, "R5 long8 128k");

    rate = 2'b10; short_m = 1'b1;
    wait_fs();
    run_frames(3, 64, 1, 1, 7.8125, "R6 short 512k");

    sup = 1'b1;
    wait_fs();
    run_frames(2, 64, 0, 1, 7.8125, "R7 suppressed");

    sup = 1'b0; short_m = 1'b0; rate = 2'b11;
    wait_fs();
    run_frames(3, 32, 8, 0, 15.625, "R2 rate 11");

    // stop mid-frame
    wait_fs();
    @(negedge clk_i);
    en = 1'b0;
    n = 0;
    repeat (700) begin @(negedge clk_i); if (b_rise) n++; end
    chk(n == 31, "R9 rises after disable", n, 31);
    chk(pcm_clk == 0 && pcm_sync == 0, "R9 stopped low", {pcm_clk, pcm_sync}, 0);

    // restart in short mode at 128 kHz
    short_m = 1'b1; rate = 2'b01; en = 1'b1;
    n = 0; s = 0;
    do begin @(negedge clk_i); n++; if (pcm_sync) s++; end while (!fs);
    chk(n == 17, "R9 start latency 128k", n, 17);
    chk(s == 0, "R6 no sync before first frame", s, 0);
    run_frames(2, 16, 1, 1, 31.25, "R6 short 128k");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL R9 watchdog actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule